// File: doc/BRIEF.md
# Parallel-to-Serial Time Slot Interchanger

This block moves bytes from a byte-wide parallel frame onto several serial output streams, one bit per clock. A free-running frame counter sets the timing. During the first `PAR_SLOTS` clocks of every frame, the parallel input byte on each clock is stored at the slot number equal to the frame position. The store is double-buffered, so the serial side always reads the complete frame that came in before the current one.

Each serial output slot (stream `s`, channel `c`) owns one 16-bit entry in a connection table, which a CPU writes through a simple one-cycle write port. The entry holds the parallel source slot. It also holds a message-mode flag that sends a constant byte from the entry in place of switched data, plus a driver-enable and a direction bit that are held for the whole 8-bit slot. At each slot boundary every stream loads its byte into a shift register and sends it MSB first.

Typical use: the CPU fills the table once. It then rewrites single entries while traffic runs, and every rewrite takes effect at the next boundary of that slot.

Top module: `ptsi_top`

## Requirements
- R1: While `rst` is high and after its release edge, `ser_oe` is all zero, `ser_dat` is all zero and `frm_sync` is 1. The data buffer and connection table clear to zero.
- R2: `frm_sync` is high for exactly one clock in every `CHANS*8` clocks. The edge at which it is high is frame position 0.
- R3: The parallel byte on `par_din` at frame position `p < PAR_SLOTS` is stored as slot `p`. It is served to the serial side only during the following frame.
- R4: A switched entry (bit 12 clear) outputs the stored byte of the slot given by entry bits [11:0]. Bits above the buffer address width are ignored.
- R5: A message entry (bit 12 set) outputs entry bits [7:0] in place of buffered data.
- R6: Counting frame edges from 0, after edge `c*8+k` each stream shows bit `7-k` of its channel `c` byte. The byte goes out MSB first.
- R7: Entry bit 14 drives `ser_oe` for the whole slot. When it is clear, `ser_dat` stays 0 for that slot.
- R8: Entry bit 13 drives `ser_dir` for the whole slot. The value is held constant inside the slot.
- R9: The table address of stream `s`, channel `c` is `s*CHANS + c`, in stream-major order. Addresses at or above `STREAMS*CHANS` are never written.
- R10: A table write changes only slots loaded after its write edge. A slot already shifting keeps its byte and controls.
- R11: One parallel slot can feed any number of serial slots in the same frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one serial bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| par_din | input | 8 | Parallel input byte, sampled at frame positions below PAR_SLOTS |
| cm_we | input | 1 | Connection table write strobe |
| cm_addr | input | CM_AW | Connection table address (stream-major) |
| cm_wdata | input | 16 | Entry: [11:0] source, [12] message, [13] direction, [14] enable |
| frm_sync | output | 1 | High while the frame position is 0 |
| ser_dat | output | STREAMS | Serial data per stream, 0 while disabled |
| ser_oe | output | STREAMS | Per-slot driver enable per stream |
| ser_dir | output | STREAMS | Per-slot direction control per stream |

## Verification
The bench aims first at the frame-buffer swap. A buffer that swapped one edge late, or read the bank being written, would put the current frame's byte, or a torn mix of two frames, on the serial lines. It then rewrites an entry in the middle of a slot. A design that looked the entry up on every bit would corrupt the slot already on the wire. Other targets are source values with high address bits set, one parallel slot fanned out to two streams, and the stream-major table layout, where a swapped row and column would land a message byte on the wrong stream. Disabled slots must hold `ser_dat` low. A design that gated only the first bit would leak the remaining seven bits.

// File: rtl/ptsi_pkg.sv
package ptsi_pkg;

    localparam int ENTRY_W = 16;
    localparam int SRC_W   = 12;

    // Connection table entry; bit positions are part of the CPU contract.
    typedef struct packed {
        logic             spare;   // [15]
        logic             oe;      // [14]
        logic             dir;     // [13]
        logic             msg;     // [12]
        logic [SRC_W-1:0] src;     // [11:0]
    } conn_entry_t;

    // What one serial lane needs at a slot boundary.
    typedef struct packed {
        logic       oe;
        logic       dir;
        logic [7:0] data;
    } slot_load_t;

    function automatic slot_load_t make_load(conn_entry_t e, logic [7:0] buffered);
        slot_load_t l;
        l.oe   = e.oe;
        l.dir  = e.dir;
        l.data = e.msg ? e.src[7:0] : buffered;
        return l;
    endfunction

endpackage

// File: rtl/ptsi_frame_ctr.sv
module ptsi_frame_ctr #(
    parameter  int FRAME_CLKS = 256,
    localparam int POS_W      = $clog2(FRAME_CLKS)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [POS_W-1:0] pos,
    output logic             wr_bank,
    output logic             sync
);

    localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_CLKS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos     <= '0;
            wr_bank <= 1'b0;
        end else if (pos == LAST) begin
            pos     <= '0;
            wr_bank <= ~wr_bank;
        end else begin
            pos <= pos + 1'b1;
        end
    end

    assign sync = (pos == '0);

endmodule

// File: rtl/ptsi_data_buf.sv
module ptsi_data_buf #(
    parameter  int SLOTS = 64,
    parameter  int PORTS = 4,
    localparam int AW    = $clog2(SLOTS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [7:0]                wr_data,
    input  logic                      wr_bank,
    input  logic [PORTS-1:0][AW-1:0]  rd_addr,
    output logic [PORTS-1:0][7:0]     rd_data
);

    logic [7:0] mem [2][SLOTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < 2; b++)
                for (int i = 0; i < SLOTS; i++)
                    mem[b][i] <= '0;
        end else if (wr_en) begin
            mem[wr_bank][wr_addr] <= wr_data;
        end
    end

    // Readers always see the bank filled during the previous frame.
    for (genvar p = 0; p < PORTS; p++) begin : g_rd
        assign rd_data[p] = mem[~wr_bank][rd_addr[p]];
    end

endmodule

// File: rtl/ptsi_conn_mem.sv
module ptsi_conn_mem #(
    parameter  int ENTRIES = 128,
    parameter  int PORTS   = 4,
    parameter  int W       = 16,
    localparam int AW      = $clog2(ENTRIES)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [W-1:0]             wr_data,
    input  logic [PORTS-1:0][AW-1:0] rd_addr,
    output logic [PORTS-1:0][W-1:0]  rd_data
);

    logic [W-1:0] tbl [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++)
                tbl[i] <= '0;
        end else if (wr_en) begin
            tbl[wr_addr] <= wr_data;
        end
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_rd
        assign rd_data[p] = tbl[rd_addr[p]];
    end

endmodule

// File: rtl/ptsi_lane.sv
module ptsi_lane
    import ptsi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  slot_load_t nxt,
    output logic       ser_dat,
    output logic       ser_oe,
    output logic       ser_dir
);

    logic [7:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            ser_oe  <= 1'b0;
            ser_dir <= 1'b0;
        end else if (load) begin
            shreg   <= nxt.data;
            ser_oe  <= nxt.oe;
            ser_dir <= nxt.dir;
        end else begin
            shreg <= {shreg[6:0], 1'b0};
        end
    end

    assign ser_dat = shreg[7] & ser_oe;

endmodule

// File: rtl/ptsi_top.sv
module ptsi_top
    import ptsi_pkg::*;
#(
    parameter  int PAR_SLOTS = 64,
    parameter  int STREAMS   = 4,
    parameter  int CHANS     = 32,
    localparam int CM_AW     = $clog2(STREAMS * CHANS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [7:0]         par_din,
    input  logic               cm_we,
    input  logic [CM_AW-1:0]   cm_addr,
    input  logic [15:0]        cm_wdata,
    output logic               frm_sync,
    output logic [STREAMS-1:0] ser_dat,
    output logic [STREAMS-1:0] ser_oe,
    output logic [STREAMS-1:0] ser_dir
);

    localparam int FRAME_CLKS = CHANS * 8;
    localparam int POS_W      = $clog2(FRAME_CLKS);
    localparam int CH_W       = POS_W - 3;
    localparam int DM_AW      = $clog2(PAR_SLOTS);
    localparam int ENTRIES    = STREAMS * CHANS;

    logic [POS_W-1:0] pos;
    logic             wr_bank;
    logic [CH_W-1:0]  chan;
    logic             slot_start;
    logic             par_we;

    ptsi_frame_ctr #(.FRAME_CLKS(FRAME_CLKS)) u_frame (
        .clk     (clk),
        .rst     (rst),
        .pos     (pos),
        .wr_bank (wr_bank),
        .sync    (frm_sync)
    );

    assign chan       = pos[POS_W-1:3];
    assign slot_start = (pos[2:0] == 3'd0);
    assign par_we     = ({1'b0, pos} < (POS_W+1)'(PAR_SLOTS));

    logic [STREAMS-1:0][CM_AW-1:0]   cm_raddr;
    logic [STREAMS-1:0][ENTRY_W-1:0] cm_rdata;
    logic [STREAMS-1:0][DM_AW-1:0]   dm_raddr;
    logic [STREAMS-1:0][7:0]         dm_rdata;

    ptsi_conn_mem #(.ENTRIES(ENTRIES), .PORTS(STREAMS), .W(ENTRY_W)) u_conn (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cm_we),
        .wr_addr (cm_addr),
        .wr_data (cm_wdata),
        .rd_addr (cm_raddr),
        .rd_data (cm_rdata)
    );

    ptsi_data_buf #(.SLOTS(PAR_SLOTS), .PORTS(STREAMS)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (par_we),
        .wr_addr (pos[DM_AW-1:0]),
        .wr_data (par_din),
        .wr_bank (wr_bank),
        .rd_addr (dm_raddr),
        .rd_data (dm_rdata)
    );

    for (genvar s = 0; s < STREAMS; s++) begin : g_stream
        conn_entry_t ent;
        slot_load_t  nxt;

        assign cm_raddr[s] = CM_AW'(s * CHANS) + CM_AW'(chan);
        assign ent         = conn_entry_t'(cm_rdata[s]);
        assign dm_raddr[s] = ent.src[DM_AW-1:0];
        assign nxt         = make_load(ent, dm_rdata[s]);

        ptsi_lane u_lane (
            .clk     (clk),
            .rst     (rst),
            .load    (slot_start),
            .nxt     (nxt),
            .ser_dat (ser_dat[s]),
            .ser_oe  (ser_oe[s]),
            .ser_dir (ser_dir[s])
        );
    end

endmodule

// File: rtl/ptsi_chk.sv
module ptsi_chk #(
    parameter  int FRAME_CLKS = 256,
    parameter  int STREAMS    = 4,
    parameter  int ENTRIES    = 128,
    parameter  int CM_AW      = 7,
    localparam int CW         = $clog2(FRAME_CLKS)
) (
    input logic               clk,
    input logic               rst,
    input logic               frm_sync,
    input logic [STREAMS-1:0] ser_oe,
    input logic [STREAMS-1:0] ser_dir,
    input logic               cm_we,
    input logic [CM_AW-1:0]   cm_addr
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt == CW'(FRAME_CLKS - 1))
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (ser_oe == '0) && frm_sync);

    assert_sync_period_R2: assert property (@(posedge clk) disable iff (rst)
        frm_sync == (cnt == '0));

    assert_oe_held_R7: assert property (@(posedge clk) disable iff (rst)
        (cnt[2:0] != 3'd0) |=> $stable(ser_oe));

    assert_dir_held_R8: assert property (@(posedge clk) disable iff (rst)
        (cnt[2:0] != 3'd0) |=> $stable(ser_dir));

    assert_addr_range_R9: assert property (@(posedge clk) disable iff (rst)
        cm_we |-> ({1'b0, cm_addr} < (CM_AW+1)'(ENTRIES)));

endmodule

bind ptsi_top ptsi_chk #(
    .FRAME_CLKS (FRAME_CLKS),
    .STREAMS    (STREAMS),
    .ENTRIES    (ENTRIES),
    .CM_AW      (CM_AW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .frm_sync (frm_sync),
    .ser_oe   (ser_oe),
    .ser_dir  (ser_dir),
    .cm_we    (cm_we),
    .cm_addr  (cm_addr)
);

// File: tb/ptsi_top_test.sv
`timescale 1ns/1ps
module ptsi_top_test;

    localparam int PS = 64;
    localparam int NS = 4;
    localparam int NC = 32;
    localparam int FR = NC * 8;
    localparam int NE = NS * NC;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    par_din = '0;
    logic          cm_we = 1'b0;
    logic [6:0]    cm_addr = '0;
    logic [15:0]   cm_wdata = '0;
    logic          frm_sync;
    logic [NS-1:0] ser_dat, ser_oe, ser_dir;

    always #2.5 clk = ~clk;

    ptsi_top uut (
        .clk(clk), .rst(rst), .par_din(par_din), .cm_we(cm_we),
        .cm_addr(cm_addr), .cm_wdata(cm_wdata), .frm_sync(frm_sync),
        .ser_dat(ser_dat), .ser_oe(ser_oe), .ser_dir(ser_dir)
    );

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    function automatic logic [7:0] pat(input int fr, input int p);
        return 8'(p * 13 + fr * 7) ^ 8'h5A;
    endfunction

    // ---------------- behavioural reference model ----------------
    int         mpos = 0;
    int         mframe = 0;
    int         last_pos = 0;
    bit         mwb = 1'b0;
    logic [7:0] mdm [2][PS];
    logic [15:0] mcm [NE];
    logic [7:0] msh [NS];
    bit         moe [NS];
    bit         mdir [NS];
    bit         mmsg [NS];
    bit         cap [NS][FR];

    always @(posedge clk) begin
        if (rst) begin
            mpos = 0; mwb = 1'b0; mframe = 0;
            foreach (mdm[b, i]) mdm[b][i] = '0;
            foreach (mcm[i]) mcm[i] = '0;
            for (int s = 0; s < NS; s++) begin
                msh[s] = '0; moe[s] = 1'b0; mdir[s] = 1'b0; mmsg[s] = 1'b0;
            end
        end else begin
            if (mpos % 8 == 0) begin
                for (int s = 0; s < NS; s++) begin
                    logic [15:0] e;
                    e = mcm[s * NC + mpos / 8];
                    mmsg[s] = e[12];
                    msh[s]  = e[12] ? e[7:0] : mdm[!mwb][e[5:0]];
                    moe[s]  = e[14];
                    mdir[s] = e[13];
                end
            end else begin
                for (int s = 0; s < NS; s++) msh[s] = msh[s] << 1;
            end
            if (mpos < PS) mdm[mwb][mpos] = par_din;
            if (cm_we) mcm[cm_addr] = cm_wdata;
            last_pos = mpos;
            if (mpos == FR - 1) begin
                mpos = 0; mwb = !mwb; mframe++;
            end else begin
                mpos++;
            end
        end
    end

    // Compare and capture away from the active edge.
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(frm_sync == (mpos == 0), "R2 frm_sync", frm_sync, mpos == 0);
            for (int s = 0; s < NS; s++) begin
                bit expd;
                expd = moe[s] ? msh[s][7] : 1'b0;
                chk(ser_oe[s] == moe[s], "R7 ser_oe", ser_oe[s], moe[s]);
                chk(ser_dir[s] == mdir[s], "R8 ser_dir", ser_dir[s], mdir[s]);
                chk(ser_dat[s] == expd, mmsg[s] ? "R5 ser_dat" : "R4 ser_dat",
                    ser_dat[s], expd);
                cap[s][last_pos] = ser_dat[s];
            end
            par_din <= pat(mframe, mpos);
        end
    end

    function automatic logic [7:0] got_byte(input int s, input int c);
        logic [7:0] b;
        for (int k = 0; k < 8; k++) b[7-k] = cap[s][c * 8 + k];
        return b;
    endfunction

    // Waits for the current frame to end; returns its index once captured.
    task automatic wait_frame_end(output int f);
        f = mframe;
        wait (mframe != f);
        @(negedge clk);
        #1;
    endtask

    task automatic cm_write(input int a, input logic [15:0] d);
        @(negedge clk);
        cm_we = 1'b1; cm_addr = 7'(a); cm_wdata = d;
        @(negedge clk);
        cm_we = 1'b0;
    endtask

    function automatic logic [15:0] entry_for(input int a);
        int c;
        logic [15:0] e;
        c = a % NC;
        e = 16'((a * 5 + 3) % PS);
        if (c % 4 == 2) e[11:6] = 6'b110011;        // ignored high source bits
        if (c % 6 == 1) e = {8'h10, 8'(a * 3 + 1)}; // message mode
        if (c % 5 != 3) e[14] = 1'b1;
        if (c % 3 == 0) e[13] = 1'b1;
        if (a == 0 || a == NE - 1) e = 16'h400A;   // fan-out of slot 10
        if (a == 68) e = 16'h503C;                 // stream 2 ch 4 message
        if (a == 36) e = 16'h4014;                 // stream 1 ch 4 switched
        return e;
    endfunction

    initial begin
        int f;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(ser_oe == '0, "R1 ser_oe", ser_oe, 0);
        chk(ser_dat == '0, "R1 ser_dat", ser_dat, 0);
        chk(frm_sync == 1'b1, "R1 frm_sync", frm_sync, 1);
        rst = 1'b0;

        for (int a = 0; a < NE; a++) cm_write(a, entry_for(a));
        wait_frame_end(f);
        wait_frame_end(f);
        wait_frame_end(f);

        // R11: one parallel slot on two streams
        chk(got_byte(0, 0) == pat(f - 1, 10), "R11 s0c0", got_byte(0, 0), pat(f - 1, 10));
        chk(got_byte(3, 31) == pat(f - 1, 10), "R11 s3c31", got_byte(3, 31), pat(f - 1, 10));
        // R3: previous frame's byte at slot 20
        chk(got_byte(1, 4) == pat(f - 1, 20), "R3 s1c4", got_byte(1, 4), pat(f - 1, 20));
        // R9: stream-major addressing of a message entry
        chk(got_byte(2, 4) == 8'h3C, "R9 s2c4", got_byte(2, 4), 8'h3C);
        // R6: MSB-first message byte (entry 1 -> 8'h04)
        chk(got_byte(0, 1) == 8'h04, "R6 s0c1", got_byte(0, 1), 8'h04);
        // R4: high source bits ignored (entry 2 source 13)
        chk(got_byte(0, 2) == pat(f - 1, 13), "R4 s0c2", got_byte(0, 2), pat(f - 1, 13));
        // R7: disabled slot stays low (s0 c3)
        chk(got_byte(0, 3) == 8'h00, "R7 s0c3", got_byte(0, 3), 0);
        // R5: message byte on stream 1 ch 7 (a=39 -> 8'h76)
        chk(got_byte(1, 7) == 8'h76, "R5 s1c7", got_byte(1, 7), 8'h76);

        // R10: rewrite s0 c2 while it shifts
        wait (mpos == 19);
        cm_write(2, 16'h5077);
        wait_frame_end(f);
        chk(got_byte(0, 2) == pat(f - 1, 13), "R10 slot in flight", got_byte(0, 2), pat(f - 1, 13));
        wait_frame_end(f);
        chk(got_byte(0, 2) == 8'h77, "R10 next slot", got_byte(0, 2), 8'h77);

        finish_run();
    end

    initial begin
        #(5.0 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

endmodule